// File: doc/BRIEF.md
# Blocking Request Port with Retry

This block is the acceptance gate at the processor-facing request port of a cache. A requester offers work with a valid/ready handshake. The cache core can hold the port shut for several independent reasons. Each reason has its own bit in a cause register, and the core raises and drops these bits with per-bit set and clear strobes. While any bit is set, the port refuses new requests.

A refusal is never silent. The port records that it owes the requester a retry. Once the last cause has dropped, it issues a single-cycle retry pulse one cycle later, and only then does it take requests again. If a cause is raised again before that pulse goes out, the pulse is withdrawn. It is reissued after the port next comes fully unblocked. For each cause, the block also counts the cycles spent blocked, and it counts how many blocked episodes have begun. These counts are status outputs.

Top module: `req_port_gate`

## Requirements
- R1: `blocked` is high exactly while at least one cause bit is set. Bit i is set by `cause_set[i]` and cleared by `cause_clr[i]`, the change being visible from the next cycle. If both strobes are high in the same cycle, set wins. After reset no cause is set.
- R2: `req_ready` is low while the port is blocked or a retry is owed. A request offered while `req_ready` is low is refused, and it marks a retry as owed.
- R3: A request offered while `req_ready` is high is accepted, and no retry pulse follows it.
- R4: When a retry is owed and the cause register becomes all clear, `retry_pulse` is high for exactly one cycle. That cycle is the second cycle in which `blocked` is low, never the first.
- R5: If a cause is set during the cycle in which the retry is scheduled, so that the port is blocked again when the pulse would go out, the pulse is withdrawn. The retry stays owed.
- R6: Sending the retry pulse clears the owed retry. If no request is offered in the pulse cycle, `req_ready` is high in the next cycle unless the port is blocked.
- R7: Setting a cause that is already set, or clearing one that is already clear, changes neither `blocked`, `req_ready`, `retry_pulse`, nor the start count.
- R8: `block_cycles` holds one CNT_W-bit field per cause, with cause i at bits [i*CNT_W +: CNT_W]. Each field adds one for every cycle in which its cause bit is set, and it saturates at all ones.
- R9: `block_starts` adds one whenever the cause register goes from all clear to non-zero, and it saturates at all ones.
- R10: A request is never accepted in the same cycle as a retry pulse. Every run of refused requests is answered by exactly one retry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester offers a request |
| req_ready | output | 1 | Port will accept a request this cycle |
| cause_set | input | NUM_CAUSES | Per-cause set strobes from the cache core |
| cause_clr | input | NUM_CAUSES | Per-cause clear strobes from the cache core |
| blocked | output | 1 | Any cause bit is set |
| retry_pulse | output | 1 | One-cycle retry indication to the requester |
| block_cycles | output | NUM_CAUSES*CNT_W | Per-cause blocked-cycle counters |
| block_starts | output | CNT_W | Number of blocked episodes begun |

## Verification
The hardest case to reach is withdrawal. A cause must be raised in the one cycle after the register empties and before the pulse leaves, and this has to happen while a retry is owed. The directed part of the bench builds this case exactly: it causes a refusal, clears the cause, and re-sets a cause in the first unblocked cycle. A long sweep with sparse strobes and a narrow counter width then reaches re-blocking at random moments, refusals on the pulse cycle, and counter saturation.

// File: rtl/rpg_pkg.sv
// Shared types for the request port gate.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rpg_pkg;
    // Outcome of the request handshake in one cycle.
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_TAKE   = 2'd1,
        HS_REFUSE = 2'd2
    } hs_e;
endpackage

// File: rtl/rpg_cause_reg.sv
// Blocking cause register: one bit per cause, each with its own set and
// clear strobe. Set wins over clear in the same cycle.
// Assumes: strobes are synchronous to clk.
module rpg_cause_reg #(
    parameter int NUM_CAUSES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] cause_set,
    input  logic [NUM_CAUSES-1:0] cause_clr,
    output logic [NUM_CAUSES-1:0] cause_q,
    output logic [NUM_CAUSES-1:0] cause_d,
    output logic                  blocked
);
    // Next cause state: clear first, then apply sets so set wins.
    always_comb cause_d = (cause_q & ~cause_clr) | cause_set;

    // Hold the cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    // Port is blocked while any cause is present.
    always_comb blocked = |cause_q;
endmodule

// File: rtl/rpg_retry_ctl.sv
// Retry controller: decides acceptance, remembers an owed retry after a
// refusal and issues a single retry pulse one cycle after the port is
// fully unblocked; withdraws it if the port re-blocks first.
// Assumes: next_clear reflects the cause register's next state.
module rpg_retry_ctl
    import rpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic blocked,
    input  logic next_clear,
    output logic req_ready,
    output logic retry_pulse
);
    logic owed_q;
    logic sched_q;
    hs_e  hs;

    // Acceptance only with no block and no retry outstanding.
    always_comb req_ready = !blocked && !owed_q;

    // Classify this cycle's handshake.
    always_comb begin
        if (!req_valid)     hs = HS_IDLE;
        else if (req_ready) hs = HS_TAKE;
        else                hs = HS_REFUSE;
    end

    // Track the owed retry: refusal sets it, the pulse or acceptance clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  owed_q <= 1'b0;
        else if (hs == HS_REFUSE)    owed_q <= 1'b1;
        else if (sched_q)            owed_q <= 1'b0;
        else if (hs == HS_TAKE)      owed_q <= 1'b0;
    end

    // Schedule the pulse for next cycle unless a cause reappears meanwhile.
    always_ff @(posedge clk) begin
        if (!rst_n) sched_q <= 1'b0;
        else        sched_q <= owed_q && !blocked && !sched_q && next_clear;
    end

    // The scheduled pulse is the retry output.
    always_comb retry_pulse = sched_q;
endmodule

// File: rtl/rpg_block_stats.sv
// Blocking statistics: per-cause saturating counters of blocked cycles
// and a saturating count of blocked episodes begun.
// Assumes: CNT_W >= 1.
module rpg_block_stats #(
    parameter int NUM_CAUSES = 3,
    parameter int CNT_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CAUSES-1:0]       cause_q,
    input  logic [NUM_CAUSES-1:0]       cause_d,
    output logic [NUM_CAUSES*CNT_W-1:0] block_cycles,
    output logic [CNT_W-1:0]            block_starts
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] starts_q;
    logic             episode_begins;

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cause
        logic [CNT_W-1:0] cyc_q;
        // Count cycles this cause is held, stopping at the ceiling.
        always_ff @(posedge clk) begin
            if (!rst_n)                          cyc_q <= '0;
            else if (cause_q[i] && cyc_q != CNT_MAX) cyc_q <= cyc_q + 1'b1;
        end
        assign block_cycles[i*CNT_W +: CNT_W] = cyc_q;
    end

    // An episode begins when the register leaves all-clear.
    always_comb episode_begins = (cause_q == '0) && (cause_d != '0);

    // Count episodes, stopping at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 starts_q <= '0;
        else if (episode_begins && starts_q != CNT_MAX) starts_q <= starts_q + 1'b1;
    end

    assign block_starts = starts_q;
endmodule

// File: rtl/req_port_gate.sv
// Request port gate: top level joining the cause register, the retry
// controller and the blocking statistics.
// Assumes: a single clock domain and a synchronous active-low reset.
module req_port_gate #(
    parameter int NUM_CAUSES = 3,
    parameter int CNT_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_CAUSES-1:0]       cause_set,
    input  logic [NUM_CAUSES-1:0]       cause_clr,
    output logic                        blocked,
    output logic                        retry_pulse,
    output logic [NUM_CAUSES*CNT_W-1:0] block_cycles,
    output logic [CNT_W-1:0]            block_starts
);
    logic [NUM_CAUSES-1:0] cause_q;
    logic [NUM_CAUSES-1:0] cause_d;
    logic                  next_clear;

    rpg_cause_reg #(.NUM_CAUSES(NUM_CAUSES)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_set (cause_set),
        .cause_clr (cause_clr),
        .cause_q   (cause_q),
        .cause_d   (cause_d),
        .blocked   (blocked)
    );

    // Next-state emptiness of the cause register feeds retry scheduling.
    always_comb next_clear = (cause_d == '0);

    rpg_retry_ctl u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .blocked     (blocked),
        .next_clear  (next_clear),
        .req_ready   (req_ready),
        .retry_pulse (retry_pulse)
    );

    rpg_block_stats #(.NUM_CAUSES(NUM_CAUSES), .CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause_q      (cause_q),
        .cause_d      (cause_d),
        .block_cycles (block_cycles),
        .block_starts (block_starts)
    );
endmodule

// File: rtl/rpg_checker.sv
// Protocol checker for the request port gate, bound to every instance.
// Assumes: observes ports only.
module rpg_checker #(
    parameter int NUM_CAUSES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [NUM_CAUSES-1:0] cause_set,
    input logic                  blocked,
    input logic                  retry_pulse
);
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && retry_pulse));

    assert_set_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_set) |=> blocked);

    assert_blocked_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !req_ready);

    assert_refusal_owes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !req_ready);

    assert_retry_unblocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> !blocked);

    assert_retry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |=> !retry_pulse);

    assert_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && (|cause_set)) |=> !retry_pulse);

    assert_retry_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_pulse && !req_valid) |=> (req_ready == !blocked));
endmodule

bind req_port_gate rpg_checker #(.NUM_CAUSES(NUM_CAUSES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cause_set   (cause_set),
    .blocked     (blocked),
    .retry_pulse (retry_pulse)
);

// File: tb/sim_req_port_gate.sv
module sim_req_port_gate;
    localparam int PERIOD = 10;
    localparam int NC     = 3;
    localparam int CW     = 6;
    localparam int SWEEP  = 4000;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [NC-1:0]     cause_set = '0;
    logic [NC-1:0]     cause_clr = '0;
    logic              req_ready;
    logic              blocked;
    logic              retry_pulse;
    logic [NC*CW-1:0]  block_cycles;
    logic [CW-1:0]     block_starts;

    req_port_gate #(.NUM_CAUSES(NC), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .cause_set(cause_set), .cause_clr(cause_clr), .blocked(blocked),
        .retry_pulse(retry_pulse), .block_cycles(block_cycles),
        .block_starts(block_starts)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state computed from the requirements.
    logic [NC-1:0] m_cause;
    logic          m_owed, m_sched;
    logic [CW-1:0] m_cyc [NC];
    logic [CW-1:0] m_starts;
    int            refusals_open;
    logic          o_ready, o_retry, o_blocked;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cause = '0; m_owed = 0; m_sched = 0; m_starts = '0; refusals_open = 0;
        for (int i = 0; i < NC; i++) m_cyc[i] = '0;
    endtask

    // One cycle: drive after negedge, compare before posedge, then advance model.
    task automatic step(input logic v, input logic [NC-1:0] s, input logic [NC-1:0] c);
        logic e_block, e_ready, refused, taken;
        logic [NC-1:0] nc;
        @(negedge clk);
        req_valid = v; cause_set = s; cause_clr = c;
        #1;
        o_ready = req_ready; o_retry = retry_pulse; o_blocked = blocked;
        e_block = |m_cause;
        e_ready = !e_block && !m_owed;
        chk(blocked == e_block, "R1 blocked", blocked, e_block);
        chk(req_ready == e_ready, "R2 ready", req_ready, e_ready);
        chk(retry_pulse == m_sched, "R4 retry", retry_pulse, m_sched);
        chk(block_starts == m_starts, "R9 starts", block_starts, m_starts);
        for (int i = 0; i < NC; i++)
            chk(block_cycles[i*CW +: CW] == m_cyc[i], "R8 cycles", block_cycles[i*CW +: CW], m_cyc[i]);
        taken = v && e_ready;
        refused = v && !e_ready;
        chk(!(taken && retry_pulse), "R10 overlap", int'(taken), 0);
        if (retry_pulse) begin
            chk(refusals_open > 0, "R10 retry answers a refusal", refusals_open, 1);
            refusals_open = 0;
        end
        if (refused) refusals_open++;
        nc = (m_cause & ~c) | s;
        for (int i = 0; i < NC; i++)
            if (m_cause[i] && m_cyc[i] != CMAX) m_cyc[i] = m_cyc[i] + 1'b1;
        if (m_cause == '0 && nc != '0 && m_starts != CMAX) m_starts = m_starts + 1'b1;
        begin
            logic n_sched;
            n_sched = m_owed && !e_block && !m_sched && (nc == '0);
            if (refused)      m_owed = 1;
            else if (m_sched) m_owed = 0;
            else if (taken)   m_owed = 0;
            m_sched = n_sched;
        end
        m_cause = nc;
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // Reset state (R1, R2).
        step(0, '0, '0);
        chk(o_ready == 1 && o_blocked == 0 && o_retry == 0, "R1 R2 reset", o_ready, 1);

        // R3: accepted request leaves no retry.
        step(1, '0, '0);
        step(0, '0, '0);
        chk(o_ready == 1 && o_retry == 0, "R3 accept no retry", o_retry, 0);
        step(0, '0, '0);
        chk(o_retry == 0, "R3 still no retry", o_retry, 0);

        // R4/R6: refuse, unblock, pulse on second unblocked cycle.
        step(0, 3'b001, '0);
        step(1, '0, '0);
        chk(o_ready == 0, "R2 refused while blocked", o_ready, 0);
        step(0, '0, 3'b001);
        step(0, '0, '0);
        chk(o_blocked == 0 && o_retry == 0, "R4 no pulse on first unblocked cycle", o_retry, 0);
        step(0, '0, '0);
        chk(o_retry == 1 && o_ready == 0, "R4 pulse on second cycle", o_retry, 1);
        step(0, '0, '0);
        chk(o_retry == 0 && o_ready == 1, "R6 owed cleared by pulse", o_ready, 1);

        // R5: re-block in the scheduling cycle withdraws the pulse.
        step(0, 3'b010, '0);
        step(1, '0, '0);
        step(0, '0, 3'b010);
        step(0, 3'b100, '0);
        step(0, '0, '0);
        chk(o_retry == 0 && o_blocked == 1, "R5 pulse withdrawn", o_retry, 0);
        step(0, '0, 3'b100);
        step(0, '0, '0);
        chk(o_retry == 0 && o_ready == 0, "R5 retry still owed", o_ready, 0);
        step(0, '0, '0);
        chk(o_retry == 1, "R5 reissued pulse", o_retry, 1);

        // R7: redundant set and clear have no effect.
        step(0, 3'b001, '0);
        step(1, 3'b001, 3'b100);
        chk(o_blocked == 1 && o_ready == 0, "R7 redundant strobes", o_blocked, 1);
        step(0, 3'b001, 3'b010);
        chk(o_retry == 0, "R7 no spurious retry", o_retry, 0);
        step(0, '0, 3'b101);
        step(0, '0, 3'b001);
        step(0, '0, '0);
        chk(o_retry == 1, "R7 retry unaffected", o_retry, 1);

        // Set wins over clear (R1).
        step(0, 3'b010, 3'b010);
        step(0, '0, '0);
        chk(o_blocked == 1, "R1 set wins", o_blocked, 1);
        step(0, '0, 3'b010);

        // Sweep: sparse strobes, frequent requests; exercises saturation (R8, R9).
        for (int k = 0; k < SWEEP; k++) begin
            logic [NC-1:0] s, c;
            s = '0; c = '0;
            for (int i = 0; i < NC; i++) begin
                s[i] = ($urandom % 7) == 0;
                c[i] = ($urandom % 4) == 0;
            end
            step(($urandom % 3) != 0, s, c);
        end
        // Drain: release everything and let any owed retry go out (R10).
        step(0, '0, '1);
        for (int k = 0; k < 4; k++) step(0, '0, '0);
        chk(refusals_open == 0, "R10 every refusal answered", refusals_open, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule